// File: doc/BRIEF.md
# Level-Sensitive Platform Interrupt Controller

This block collects up to 32 level-sensitive interrupt request lines and presents one external-interrupt line to a single supervisor-level hart. Every source has its own gate. While the gate is open, a high line sets that source's pending bit and closes the gate. The gate stays closed until software writes that source's number back as a completion. This lets the handler clear the device-side condition before the line can raise a second interrupt.

Software reaches the block through a word-indexed register port. The word index is the byte address shifted right by two. Through this port software reads the pending vector, reads and writes the enable vector, and claims and completes interrupts. There is no priority arbitration. A claim always returns the highest-numbered source that is both pending and enabled. The priority slots and the threshold word are fixed: they read as zero and ignore writes. Source 0 is reserved, because its enable bit can never be set.

The read path is a two-state machine:
- `PS_IDLE` moves to `PS_RESP` on a read strobe.
- `PS_RESP` stays in `PS_RESP` if another read strobe arrives, and otherwise returns to `PS_IDLE`.
- `bus_rvalid` is high exactly while the machine is in `PS_RESP`.

Writes are taken in any cycle.

Top module: `irqc_top`

## Requirements
- R1: After reset the pending, enable and gate-mask vectors are all zero, `ext_irq` is low and `bus_rvalid` is low.
- R2: When a line is high while its gate is open, the next clock edge sets its pending bit and closes its gate. While the gate is closed, a line that stays high does not set the pending bit again after a claim.
- R3: A read of word index 0x400 (byte 0x1000) returns the pending vector, zero-extended. Writes to that index are ignored.
- R4: Word index 0x800 (byte 0x2000) reads and writes the enable vector. Bit 0 is stored as 0 on every write, so source 0 never raises `ext_irq` and is never claimed.
- R5: A read strobed in cycle t presents its data on `bus_rdata`, with `bus_rvalid` high, in cycle t+1 only; otherwise `bus_rdata` is zero. Reads may be back to back. When read and write strobes coincide, the write is dropped.
- R6: A read of word index 0x80001 (byte 0x200004) is a claim. It returns the number of the highest-numbered source that is both pending and enabled, and clears that pending bit at the same clock edge. If there is no such source, it returns 0.
- R7: A write of N to word index 0x80001 is a completion. It opens gate N only if enable bit N is set, and ignores N >= 32. If line N is still high, pending bit N is set again at that same edge.
- R8: `ext_irq` is high exactly when some source is both pending and enabled. It follows any change of pending or enable, including a change made by an enable write.
- R9: Word indices 1 to 31, the threshold word 0x80000 (byte 0x200000) and every unmapped index read as 0. Writes to them change nothing.
- R10: Byte-address bits [1:0] do not affect decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | 32 | Level-sensitive request lines, bit n is source n |
| bus_addr | input | 26 | Byte address of the register access |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ext_irq | output | 1 | External interrupt request to the hart |

## Verification
Some internal faults leave stale state behind. A gate that never reopens, or a pending bit that survives a claim, shows up at the ports only later: as a missing or a repeated claim number, or as `ext_irq` staying high after the last claim. The bench therefore follows each claim with a pending read one cycle later.

A faulty enable or gate update alters `ext_irq` at the negedge right after the write's clock edge, so `ext_irq` is sampled there. Selection errors appear in the first claim that has two candidates. For that reason the bench keeps several lines high at once and claims them back to back.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Word indices that the register decoder recognises
    localparam int unsigned IDX_PRIO_FIRST = 1;
    localparam int unsigned IDX_PRIO_LAST  = 31;
    localparam int unsigned IDX_PEND       = 32'h0000_0400;
    localparam int unsigned IDX_ENABLE     = 32'h0000_0800;
    localparam int unsigned IDX_THRESH     = 32'h0008_0000;
    localparam int unsigned IDX_CLAIM      = 32'h0008_0001;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_PRIO,
        RS_PEND,
        RS_ENABLE,
        RS_THRESH,
        RS_CLAIM
    } regsel_e;

    typedef enum logic {
        PS_IDLE,
        PS_RESP
    } port_st_e;

endpackage

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] word_idx,
    output regsel_e           sel
);
    localparam int unsigned SPAN = ADDR_W;

    always_comb begin
        sel = RS_NONE;
        if (word_idx >= SPAN'(IDX_PRIO_FIRST) && word_idx <= SPAN'(IDX_PRIO_LAST))
            sel = RS_PRIO;
        else if (word_idx == SPAN'(IDX_PEND))
            sel = RS_PEND;
        else if (word_idx == SPAN'(IDX_ENABLE))
            sel = RS_ENABLE;
        else if (word_idx == SPAN'(IDX_THRESH))
            sel = RS_THRESH;
        else if (word_idx == SPAN'(IDX_CLAIM))
            sel = RS_CLAIM;
    end
endmodule

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lvl,
    input  logic [NSRC-1:0] claim_oh,
    input  logic [NSRC-1:0] cmpl_oh,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] gate_mask
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic pend_r;
        logic mask_r;
        logic mask_open;

        // completion reopens the gate before the line is sampled (R7)
        assign mask_open = mask_r & ~cmpl_oh[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r <= 1'b0;
                mask_r <= 1'b0;
            end else begin
                pend_r <= (pend_r & ~claim_oh[g]) | (lvl[g] & ~mask_open);
                mask_r <= mask_open | lvl[g];
            end
        end

        assign pend[g]      = pend_r;
        assign gate_mask[g] = mask_r;
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int NSRC = 32,
    parameter int IDW  = 5
) (
    input  logic [NSRC-1:0] cand,
    output logic [IDW-1:0]  id,
    output logic            any
);
    // highest-numbered candidate wins (R6)
    always_comb begin
        id  = '0;
        any = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i]) begin
                id  = IDW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              ext_irq
);
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [ADDR_W-1:0] word_idx;
    regsel_e           sel;
    logic [NSRC-1:0]   pend_q;
    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   en_q;
    logic [NSRC-1:0]   claim_oh;
    logic [NSRC-1:0]   cmpl_oh;
    logic [IDW-1:0]    pick_id;
    logic              pick_any;
    logic              wr_go;
    logic              claim_go;
    logic              cmpl_go;
    logic [DATA_W-1:0] rd_val;
    port_st_e          st_q;
    port_st_e          st_d;

    // byte address to word index; low two bits drop out (R10)
    assign word_idx = bus_addr >> 2;

    irqc_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .word_idx (word_idx),
        .sel      (sel)
    );

    irqc_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
        .cand (pend_q & en_q),
        .id   (pick_id),
        .any  (pick_any)
    );

    // a read strobe wins over a coincident write (R5)
    assign wr_go    = bus_wr & ~bus_rd;
    assign claim_go = bus_rd & (sel == RS_CLAIM);
    assign cmpl_go  = wr_go & (sel == RS_CLAIM) && (bus_wdata < DATA_W'(NSRC));

    always_comb begin
        claim_oh = '0;
        if (claim_go && pick_any)
            claim_oh[pick_id] = 1'b1;
    end

    // completion opens the gate only for an enabled source (R7)
    always_comb begin
        cmpl_oh = '0;
        if (cmpl_go && en_q[bus_wdata[IDW-1:0]])
            cmpl_oh[bus_wdata[IDW-1:0]] = 1'b1;
    end

    irqc_gateway #(.NSRC(NSRC)) u_gw (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (src_lvl),
        .claim_oh  (claim_oh),
        .cmpl_oh   (cmpl_oh),
        .pend      (pend_q),
        .gate_mask (mask_q)
    );

    // enable vector, bit 0 held at zero (R4)
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_go && sel == RS_ENABLE)
            en_q <= bus_wdata[NSRC-1:0] & ~NSRC'(1);
    end

    always_comb begin
        unique case (sel)
            RS_PEND:   rd_val = DATA_W'(pend_q);
            RS_ENABLE: rd_val = DATA_W'(en_q);
            RS_CLAIM:  rd_val = DATA_W'(pick_id);
            RS_NONE, RS_PRIO, RS_THRESH: rd_val = '0;
            default:   rd_val = '0;
        endcase
    end

    // read response state machine: state register
    always_comb begin
        unique case (st_q)
            PS_IDLE: st_d = bus_rd ? PS_RESP : PS_IDLE;
            PS_RESP: st_d = bus_rd ? PS_RESP : PS_IDLE;
            default: st_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= PS_IDLE;
        else
            st_q <= st_d;
    end

    // read response state machine: outputs (R5)
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_val;
        else
            bus_rdata <= '0;
    end

    assign bus_rvalid = (st_q == PS_RESP);
    assign ext_irq    = |(pend_q & en_q);

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NSRC = 32,
    parameter int IDW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic            bus_rvalid,
    input logic            ext_irq,
    input logic [NSRC-1:0] src_lvl,
    input logic [NSRC-1:0] en_q,
    input logic [NSRC-1:0] pend_q,
    input logic            claim_go,
    input logic [IDW-1:0]  pick_id,
    input logic            pick_any
);
    a_r5_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    a_r5_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    a_r4_enable_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        en_q[0] == 1'b0);

    a_r6_claim_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_go && pick_any && !src_lvl[pick_id]) |=> !pend_q[$past(pick_id)]);

    a_r8_irq_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_irq) |-> ($past(src_lvl) != '0) || $past(bus_wr));
endmodule

bind irqc_top irqc_chk #(.NSRC(NSRC), .IDW(IDW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rvalid (bus_rvalid),
    .ext_irq    (ext_irq),
    .src_lvl    (src_lvl),
    .en_q       (en_q),
    .pend_q     (pend_q),
    .claim_go   (claim_go),
    .pick_id    (pick_id),
    .pick_any   (pick_any)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    localparam int NSRC = 32;
    localparam logic [25:0] A_PEND  = 26'h000_1000;
    localparam logic [25:0] A_EN    = 26'h000_2000;
    localparam logic [25:0] A_THR   = 26'h020_0000;
    localparam logic [25:0] A_CLAIM = 26'h020_0004;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [25:0]     addr = '0;
    logic            rd = 1'b0;
    logic            wr = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            rvalid;
    logic            irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src), .bus_addr(addr),
        .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_rvalid(rvalid), .ext_irq(irq)
    );

    task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, e);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (exp_q.size() == 0)
                note(1'b0, "R5 unexpected response", rdata, 32'h0);
            else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                note(rdata === e, t, rdata, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_exp(input logic [25:0] a, input logic [31:0] e, input string t);
        addr = a; rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [25:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        note(irq === e, t, {31'b0, irq}, {31'b0, e});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        note(1'b0, "watchdog expired", 32'h0, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1 ext_irq after reset");
        note(rvalid === 1'b0, "R1 rvalid after reset", {31'b0, rvalid}, 32'h0);
        rd_exp(A_PEND, 32'h0, "R1 pending after reset");
        rd_exp(A_EN, 32'h0, "R1 enable after reset");
        tick(1);
        note(rdata === 32'h0, "R5 rdata idle zero", rdata, 32'h0);

        // R2 line 5 latches while disabled
        src = 32'h20; tick(1);
        chk_irq(1'b0, "R8 pending but disabled");
        rd_exp(A_PEND, 32'h20, "R3 R2 pending shows source 5");

        // R4 enable write, bit 0 forced low
        wr_reg(A_EN, 32'hFFFF_FFFF);
        chk_irq(1'b1, "R8 irq after enable write");
        rd_exp(A_EN, 32'hFFFF_FFFE, "R4 enable bit0 cleared");

        // R6 claim and R2 no re-pend while gate closed
        rd_exp(A_CLAIM, 32'd5, "R6 claim source 5");
        chk_irq(1'b0, "R8 irq low after claim");
        rd_exp(A_PEND, 32'h0, "R2 no re-pend with gate closed");

        // R6 highest-numbered wins, back-to-back reads, empty claim
        src = 32'h228; tick(1);
        chk_irq(1'b1, "R8 irq with 3 and 9");
        rd_exp(A_CLAIM, 32'd9, "R6 claim picks 9");
        rd_exp(A_CLAIM, 32'd3, "R6 R5 back-to-back claim 3");
        rd_exp(A_CLAIM, 32'd0, "R6 claim with none returns 0");

        // R7 completion with line still high re-pends
        wr_reg(A_CLAIM, 32'd5);
        rd_exp(A_PEND, 32'h20, "R7 completion re-pends source 5");
        rd_exp(A_CLAIM, 32'd5, "R6 claim 5 again");

        // R7 completion gated by enable
        wr_reg(A_EN, 32'h0000_0200);
        wr_reg(A_CLAIM, 32'd3);
        wr_reg(A_EN, 32'hFFFF_FFFF);
        rd_exp(A_PEND, 32'h0, "R7 disabled completion ignored");
        wr_reg(A_CLAIM, 32'd40);
        rd_exp(A_PEND, 32'h0, "R7 out-of-range completion ignored");
        wr_reg(A_CLAIM, 32'd3);
        rd_exp(A_PEND, 32'h08, "R7 enabled completion re-pends 3");
        rd_exp(A_CLAIM, 32'd3, "R6 claim 3");

        // R9 fixed and unmapped words
        wr_reg(26'h000_0008, 32'd7);
        rd_exp(26'h000_0008, 32'h0, "R9 priority slot reads zero");
        rd_exp(26'h000_007C, 32'h0, "R9 last priority slot reads zero");
        wr_reg(A_THR, 32'd5);
        rd_exp(A_THR, 32'h0, "R9 threshold reads zero");
        rd_exp(26'h000_3000, 32'h0, "R9 unmapped reads zero");
        wr_reg(A_PEND, 32'hFFFF);
        rd_exp(A_PEND, 32'h0, "R3 pending write ignored");

        // R10 low address bits ignored
        rd_exp(26'h000_2003, 32'hFFFF_FFFE, "R10 enable at byte offset 3");

        // R5 read wins over coincident write
        addr = A_EN; wdata = 32'h0; rd = 1'b1; wr = 1'b1;
        exp_q.push_back(32'hFFFF_FFFE); tag_q.push_back("R5 read during write");
        @(negedge clk); rd = 1'b0; wr = 1'b0;
        rd_exp(A_EN, 32'hFFFF_FFFE, "R5 coincident write dropped");

        // R8 irq follows enable changes
        src = 32'h1228; tick(1);
        chk_irq(1'b1, "R8 irq source 12");
        wr_reg(A_EN, 32'h0);
        chk_irq(1'b0, "R8 irq drops with enable cleared");
        wr_reg(A_EN, 32'hFFFF_FFFF);
        chk_irq(1'b1, "R8 irq returns with enable");
        rd_exp(A_CLAIM, 32'd12, "R6 claim 12");
        chk_irq(1'b0, "R8 irq low after claim 12");

        // R4 source 0 never interrupts
        src = 32'h1229; tick(1);
        rd_exp(A_PEND, 32'h1, "R4 source 0 pending visible");
        chk_irq(1'b0, "R4 source 0 no irq");
        rd_exp(A_CLAIM, 32'd0, "R4 source 0 not claimed");

        tick(3);
        note(exp_q.size() == 0, "R5 all responses seen", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule